// File: doc/BRIEF.md
# Serial Transmit Engine with Clear-to-Send Gating

This block turns parallel characters into an asynchronous serial stream. The host writes a character with a single-cycle strobe into a holding register. When the peripheral pulls the active-low clear-to-send input low, the character moves into a shift register. The line then carries a start bit, five to eight data bits with the least significant bit first, an optional even or odd parity bit, and one or two stop bits. Each serial bit lasts exactly one transmitter clock period, so the baud-rate divider sits outside this block.

Two flags tell the host where it stands. One shows that the holding register is free to take a new character. The other shows that the shift register has nothing left to send. A character that is already waiting when the current frame ends starts on the very next bit time, so there is no idle time between frames. An active-low interrupt goes low when the holding register frees up. It also goes low when the whole transmitter falls idle with nothing pending. A host status read or a new write releases it.

Top module: `ctsgate_uart_tx`

## Requirements
- R1: After `rst` or `clr`, `sdo` is 1, `thr_empty` is 1, `tsr_empty` is 1 and `irq_n` is 1. A `clr` in the middle of a frame aborts that frame.
- R2: A frame is one start bit (0), then N data bits sent least significant bit first, where N = 5 + `cfg_wlen` (00 gives 5 bits, 11 gives 8 bits), then the parity bit if `cfg_par_en` is 1, then one stop bit (1), or two when `cfg_stop2` is 1. Data bits at positions N and above are never sent. Each bit lasts one clock, and `sdo` is 1 whenever `tsr_empty` is 1.
- R3: Parity covers only the N configured data bits. With `cfg_par_odd` = 0 the data bits plus the parity bit hold an even number of ones; with `cfg_par_odd` = 1 they hold an odd number.
- R4: While `cts_n` is 1, no character leaves the holding register. `sdo` stays 1, `tsr_empty` stays 1 and `thr_empty` stays 0.
- R5: With `cts_n` low and the shifter free, a character written with the strobe high on clock edge P0 is loaded on edge P1, the first edge with the strobe low. Its start bit is on `sdo` from P1 until P2.
- R6: `thr_empty` rises and `irq_n` falls on the clock edge one period after the load edge.
- R7: A character waiting in the holding register, with `cts_n` low, starts its start bit in the clock period right after the previous frame's last stop bit. No idle bit comes between the two frames.
- R8: When a frame ends and the holding register is empty, `tsr_empty` rises and `irq_n` falls on the same edge.
- R9: A one-cycle `stat_rd` or `wr_stb` releases `irq_n` to 1 on the next edge, unless a new interrupt event occurs on that same edge.
- R10: The format inputs are captured at the load edge. Changing them while the frame is on the line does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmitter clock, one serial bit per period |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, same effect as reset |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| cfg_wlen | input | WL_W | Word length code, N = 5 + code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| cts_n | input | 1 | Active-low clear-to-send |
| stat_rd | input | 1 | Status read, releases the interrupt |
| sdo | output | 1 | Serial data out, idles high |
| thr_empty | output | 1 | Holding register empty |
| tsr_empty | output | 1 | Shift register empty |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sends a 5-bit character with high-order bits set and parity on. This catches a design that sends the unused bits or computes parity over all eight bits: the frame would be too long or the parity bit would be flipped. It holds clear-to-send high with a character pending and checks that nothing leaks out. It times a single write edge by edge, so a load that fires while the strobe is still high, or a late holding-empty flag, shows up as a cycle error. It also sends two characters back to back and checks for a zero-length gap. It changes the format in the middle of a frame, clears in the middle of a frame, and watches that the final interrupt falls together with the shift-empty flag.

// File: rtl/ctsgate_uart_tx_pkg.sv
package ctsgate_uart_tx_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_MIN_W  = 5;

  // Format options besides the word length
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;
endpackage

// File: rtl/ctsgate_uart_tx_hold.sv
module ctsgate_uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_stb) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ctsgate_uart_tx_frame.sv
module ctsgate_uart_tx_frame
  import ctsgate_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_W   = 5,
  parameter int unsigned WL_W    = 2,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = 4
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [WL_W-1:0]    wlen,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   flen
);
  logic [CNT_W-1:0] ndata;
  logic             par;

  always_comb begin
    ndata = CNT_W'(MIN_W) + CNT_W'(wlen);
    par   = fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int k = 0; k < DATA_W; k++) begin
      if (CNT_W'(k) < ndata) begin
        par = par ^ data[k];
        frame[k+1] = data[k];
      end
    end
    for (int i = 1; i < FRAME_W; i++) begin
      if (fmt.par_en && (CNT_W'(i) == ndata + CNT_W'(1))) frame[i] = par;
    end
    flen = ndata + CNT_W'(2) + CNT_W'(fmt.par_en) + CNT_W'(fmt.stop2);
  end
endmodule

// File: rtl/ctsgate_uart_tx_shift.sv
module ctsgate_uart_tx_shift #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               pending,
  input  logic               wr_stb,
  input  logic               cts_n,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   flen,
  output logic               load,
  output logic               idle_evt,
  output logic               sdo,
  output logic               tsr_empty
);
  logic               active;
  logic [CNT_W-1:0]   rem;
  logic [FRAME_W-1:0] shreg;
  logic               ready;

  // Free when idle or when the last stop bit is on the line
  assign ready    = !active || (rem == '0);
  assign load     = pending && !wr_stb && !cts_n && ready;
  assign idle_evt = active && (rem == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active    <= 1'b0;
      rem       <= '0;
      shreg     <= '1;
      sdo       <= 1'b1;
      tsr_empty <= 1'b1;
    end else if (load) begin
      active    <= 1'b1;
      sdo       <= frame[0];
      shreg     <= {1'b1, frame[FRAME_W-1:1]};
      rem       <= flen - CNT_W'(1);
      tsr_empty <= 1'b0;
    end else if (active) begin
      if (rem != '0) begin
        sdo   <= shreg[0];
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        rem   <= rem - CNT_W'(1);
      end else begin
        active    <= 1'b0;
        sdo       <= 1'b1;
        tsr_empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctsgate_uart_tx_flags.sv
module ctsgate_uart_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold_full,
  input  logic idle_evt,
  input  logic wr_stb,
  input  logic stat_rd,
  output logic thr_empty,
  output logic irq_n
);
  logic set_free, set_idle;

  assign set_free = !hold_full && !thr_empty;
  assign set_idle = idle_evt && !hold_full;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      thr_empty <= 1'b1;
      irq_n     <= 1'b1;
    end else begin
      thr_empty <= !hold_full;
      if (set_free || set_idle) irq_n <= 1'b0;
      else if (wr_stb || stat_rd) irq_n <= 1'b1;
    end
  end
endmodule

// File: rtl/ctsgate_uart_tx.sv
module ctsgate_uart_tx
  import ctsgate_uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned MIN_W  = DEF_MIN_W,
  localparam int unsigned WL_W    = $clog2(DATA_W - MIN_W + 1),
  localparam int unsigned FRAME_W = DATA_W + 4,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cts_n,
  input  logic              stat_rd,
  output logic              sdo,
  output logic              thr_empty,
  output logic              tsr_empty,
  output logic              irq_n
);
  logic               hold_full, load, idle_evt;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   flen;
  fmt_t               fmt;

  assign fmt = '{par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

  ctsgate_uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .clr(clr), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(load), .full(hold_full), .data(hold_data)
  );

  ctsgate_uart_tx_frame #(
    .DATA_W(DATA_W), .MIN_W(MIN_W), .WL_W(WL_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) frame_i (
    .data(hold_data), .wlen(cfg_wlen), .fmt(fmt), .frame(frame), .flen(flen)
  );

  ctsgate_uart_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst(rst), .clr(clr), .pending(hold_full), .wr_stb(wr_stb),
    .cts_n(cts_n), .frame(frame), .flen(flen), .load(load),
    .idle_evt(idle_evt), .sdo(sdo), .tsr_empty(tsr_empty)
  );

  ctsgate_uart_tx_flags flags_i (
    .clk(clk), .rst(rst), .clr(clr), .hold_full(hold_full), .idle_evt(idle_evt),
    .wr_stb(wr_stb), .stat_rd(stat_rd), .thr_empty(thr_empty), .irq_n(irq_n)
  );
endmodule

// File: rtl/ctsgate_uart_tx_chk.sv
module ctsgate_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic cts_n,
  input logic sdo,
  input logic thr_empty,
  input logic tsr_empty,
  input logic irq_n
);
  // R1: reset leaves the line high, both registers empty, no interrupt
  a_r1_reset_state: assert property (@(posedge clk) disable iff (clr)
    rst |=> (sdo && thr_empty && tsr_empty && irq_n));

  // R2: line is high whenever the shifter is empty
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    tsr_empty |-> sdo);

  // R4: clear-to-send high keeps the shifter empty
  a_r4_cts_gate: assert property (@(posedge clk) disable iff (rst || clr)
    (cts_n && tsr_empty) |=> tsr_empty);

  // R6: holding register freeing raises the interrupt on the same edge
  a_r6_free_irq: assert property (@(posedge clk) disable iff (rst || clr)
    ($rose(thr_empty) && !$past(clr)) |-> !irq_n);

  // R8: final idle with empty holding register raises the interrupt
  a_r8_final_irq: assert property (@(posedge clk) disable iff (rst || clr)
    ($rose(tsr_empty) && thr_empty && !$past(clr)) |-> !irq_n);
endmodule

bind ctsgate_uart_tx ctsgate_uart_tx_chk chk_i (
  .clk(clk), .rst(rst), .clr(clr), .cts_n(cts_n), .sdo(sdo),
  .thr_empty(thr_empty), .tsr_empty(tsr_empty), .irq_n(irq_n)
);

// File: tb/ctsgate_uart_tx_tb_top.sv
module ctsgate_uart_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1, clr = 1'b0, wr_stb = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       cts_n = 1'b0;
  logic       sdo, thr_empty, tsr_empty, irq_n;

  always #4 clk = ~clk;  // 125 MHz

  ctsgate_uart_tx dut_i (
    .clk(clk), .rst(rst), .clr(clr), .wr_stb(wr_stb), .wr_data(wr_data),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cts_n(cts_n), .stat_rd(stat_rd), .sdo(sdo),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .irq_n(irq_n)
  );

  typedef struct {
    logic [15:0] bits;
    int          len;
    string       tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_checks = 0, n_fail = 0;
  bit    flush = 1'b0, in_frame = 1'b0;
  int    idle_cnt = 99, last_gap = 99, bit_idx = 0;
  exp_t  cur;
  logic [15:0] got;
  bit    mism;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected frame straight from the requirement text (R2, R3)
  function automatic exp_t mk(input logic [7:0] d, input logic [1:0] wl,
                              input logic pe, po, s2, input string tag);
    exp_t e;
    int   n = 5 + int'(wl);
    int   ix = 0;
    logic p = po;
    e.bits = '1;
    e.bits[ix] = 1'b0; ix++;
    for (int k = 0; k < n; k++) begin
      e.bits[ix] = d[k]; p = p ^ d[k]; ix++;
    end
    if (pe) begin e.bits[ix] = p; ix++; end
    e.bits[ix] = 1'b1; ix++;
    if (s2) begin e.bits[ix] = 1'b1; ix++; end
    e.len = ix;
    e.tag = tag;
    return e;
  endfunction

  // Monitor: pops an expected frame at each start bit and compares it
  always @(negedge clk) begin
    if (rst || flush) begin
      in_frame = 1'b0;
      idle_cnt = 99;
      exp_q.delete();
    end else if (!in_frame) begin
      if (sdo === 1'b0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected start bit", 16'h0, 16'h1);
        end else begin
          cur = exp_q.pop_front();
          in_frame = 1'b1;
          bit_idx = 1;
          mism = 1'b0;
          got = '1;
          got[0] = 1'b0;
          last_gap = idle_cnt;
        end
      end else begin
        idle_cnt++;
      end
    end else begin
      got[bit_idx] = sdo;
      if (sdo !== cur.bits[bit_idx]) mism = 1'b1;
      bit_idx++;
      if (bit_idx == cur.len) begin
        chk(!mism, cur.tag, got, cur.bits);
        in_frame = 1'b0;
        idle_cnt = 0;
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] wl,
                      input logic pe, po, s2, input string tag);
    while (!thr_empty) @(negedge clk);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    exp_q.push_back(mk(d, wl, pe, po, s2, tag));
    wr_data = d;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!(exp_q.size() == 0 && !in_frame && tsr_empty && thr_empty) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "R2 frames drained", 16'(guard), 16'd0);
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sdo && thr_empty && tsr_empty && irq_n, "R1 reset state",
        {12'h0, sdo, thr_empty, tsr_empty, irq_n}, 16'hF);

    // R5/R6 exact timing of one write
    exp_q.push_back(mk(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, "R2 8-bit plain"));
    cfg_wlen = 2'd3; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;
    wr_data = 8'h3C; wr_stb = 1'b1;
    @(negedge clk);                      // after P0
    wr_stb = 1'b0;
    chk(sdo === 1'b1, "R5 no start before strobe falls", {15'h0, sdo}, 16'h1);
    @(negedge clk);                      // after P1
    chk(sdo === 1'b0 && thr_empty === 1'b0, "R5 start bit after load edge",
        {14'h0, sdo, thr_empty}, 16'h0);
    @(negedge clk);                      // after P2
    chk(thr_empty === 1'b1 && irq_n === 1'b0, "R6 holding empty and irq one clock later",
        {14'h0, thr_empty, irq_n}, 16'h2);
    pulse_rd();
    chk(irq_n === 1'b1, "R9 status read releases irq", {15'h0, irq_n}, 16'h1);
    wait_done();

    // R2/R3 formats
    send(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, "R2 5-bit high bits not sent");
    wait_done();
    send(8'hE1, 2'd0, 1'b1, 1'b0, 1'b0, "R3 5-bit even parity over 5 bits");
    wait_done();
    send(8'h2D, 2'd1, 1'b1, 1'b0, 1'b1, "R2 6-bit even parity two stops");
    wait_done();
    send(8'h55, 2'd2, 1'b1, 1'b1, 1'b0, "R3 7-bit odd parity");
    wait_done();
    send(8'h00, 2'd3, 1'b1, 1'b1, 1'b1, "R3 8-bit odd parity zero data");
    wait_done();

    // R4 clear-to-send held high
    cts_n = 1'b1;
    send(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, "R4 frame after cts falls");
    repeat (10) @(negedge clk);
    chk(sdo && !thr_empty && tsr_empty, "R4 held while cts high",
        {13'h0, sdo, thr_empty, tsr_empty}, 16'h5);
    cts_n = 1'b0;
    wait_done();

    // R7 back to back
    send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, "R7 first frame");
    send(8'h7E, 2'd2, 1'b1, 1'b0, 1'b0, "R7 second frame");
    wait_done();
    chk(last_gap == 0, "R7 no idle between frames", 16'(last_gap), 16'd0);

    // R8/R9 final interrupt
    send(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, "R8 frame");
    @(negedge clk);
    chk(irq_n === 1'b0 && tsr_empty === 1'b0, "R6 irq while shifting",
        {14'h0, irq_n, tsr_empty}, 16'h0);
    pulse_rd();
    chk(irq_n === 1'b1, "R9 irq released", {15'h0, irq_n}, 16'h1);
    while (!tsr_empty) @(negedge clk);
    chk(irq_n === 1'b0 && thr_empty === 1'b1, "R8 final irq with shifter empty",
        {14'h0, irq_n, thr_empty}, 16'h1);
    wait_done();
    pulse_rd();

    // R10 format change mid-frame
    send(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, "R10 format latched at load");
    repeat (2) @(negedge clk);
    cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_stop2 = 1'b1;
    wait_done();

    // R1 clear mid-frame
    send(8'h5A, 2'd3, 1'b1, 1'b0, 1'b1, "R1 aborted frame");
    repeat (3) @(negedge clk);
    flush = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(sdo && thr_empty && tsr_empty && irq_n, "R1 clear state",
        {12'h0, sdo, thr_empty, tsr_empty, irq_n}, 16'hF);
    repeat (16) @(negedge clk);
    chk(sdo === 1'b1, "R1 line stays high after clear", {15'h0, sdo}, 16'h1);
    flush = 1'b0;
    @(negedge clk);
    send(8'h69, 2'd1, 1'b0, 1'b0, 1'b0, "R2 frame after clear");
    wait_done();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule